// File: doc/BRIEF.md
# Loop Replay Buffer

The loop replay buffer sits on the instruction path between fetch and decode. In normal operation it is transparent: fetched words go straight to the decoder through a valid/ready handshake. When it sees a loop-setup word, it removes that word from the stream. The setup word declares two lengths: the number of control-expression words that follow and the number of body words after them. On the first pass through the loop, the block copies those words into a small ring store while they flow on to the decoder.

After the first pass, the block holds fetch and takes over the decode port. It replays the control-expression words, then pauses until the execute stage reports the exit decision. If the loop continues, it sends the body words and wraps back to the first control word, with no taken jump. If the loop exits, it skips that iteration's body, returns to pass-through and releases fetch. Fetch then resumes at the word after the body, because the first pass already consumed every word of the loop.

A flush returns the block to pass-through from any state. A two-bit mode output tells the fetch unit whether the block is idle, filling or replaying.

Top module: `loop_replay_buf`

## Requirements
- R1: After reset the mode is idle (0), fetch_hold is 0, and d_valid is 0 while f_valid is 0.
- R2: In idle mode, a word whose bits [31:24] differ from the setup opcode 0xF0 passes through unchanged: d_valid follows f_valid, d_word follows f_word, and f_ready follows d_ready.
- R3: In idle mode, a setup word (bits [31:24] = 0xF0, control length in bits [23:16], body length in bits [15:8]) is accepted with f_ready = 1 and is never presented to the decoder.
- R4: A setup word with a zero length field, or with the two lengths summing to more than DEPTH (32), is consumed and dropped, and the block stays in idle pass-through.
- R5: After a valid setup word, the next control+body words pass to the decoder in order and are stored, with mode reported as fill (1).
- R6: Once the last body word of the first pass is accepted, the block enters replay (mode 2). In replay it raises fetch_hold, keeps f_ready at 0, and presents the stored control words in order.
- R7: After the last control word of a replayed iteration is accepted, d_valid stays 0 until exit_valid is seen. If exit_taken is 1, the block returns to idle without sending that iteration's body. If exit_taken is 0, it sends the body words and then wraps to the first control word.
- R8: While replaying, a word refused by the decoder (d_ready = 0) is presented again, unchanged, in the next cycle, so no word is lost or repeated.
- R9: A flush puts the block in idle mode on the next cycle, with fetch_hold 0 and pass-through restored.
- R10: The mode output only ever takes the values 0 (idle), 1 (fill) or 2 (replay, including the wait for the exit decision).
- R11: exit_valid has no effect except while the block waits for an exit decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears loop state and returns to pass-through |
| f_valid | input | 1 | Fetch word valid |
| f_word | input | 32 | Fetch word |
| f_ready | output | 1 | Block accepts the fetch word |
| d_valid | output | 1 | Decode word valid |
| d_word | output | 32 | Word to the decoder |
| d_ready | input | 1 | Decoder accepts the word |
| exit_valid | input | 1 | Exit decision is present |
| exit_taken | input | 1 | Loop exit condition met |
| fetch_hold | output | 1 | Fetch program counter must hold |
| mode | output | 2 | 0 idle, 1 fill, 2 replay |

## Verification
The bench builds programs around random loops and compares every word the decoder accepts against an expected stream it computes itself, while ready and valid stall at random.

It aims at several corner cases:
- An exit taken on the first replayed iteration, where a block that leaks the body would emit extra words.
- A loop that exactly fills the store, where an off-by-one on the wrap index would send stale or missing words.
- Malformed setup words, which a careless decoder would either forward or act on.
- Stray exit pulses during replay, which a block that samples the decision too eagerly would use to leave early.
- Decoder stalls, where a pointer that advances anyway would drop a word.
- A flush mid-replay, where a block that keeps its state would still hold fetch.

// File: rtl/lrb_pkg.sv
`timescale 1ns/1ps
package lrb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_REPLAY = 2'd2,
        ST_WAIT   = 2'd3
    } lrb_state_e;

    localparam logic [1:0] MODE_IDLE   = 2'd0;
    localparam logic [1:0] MODE_FILL   = 2'd1;
    localparam logic [1:0] MODE_REPLAY = 2'd2;

    typedef struct packed {
        logic       is_setup;
        logic       fits;
        logic [7:0] ctl_len;
        logic [8:0] sum;
    } lrb_setup_t;

    function automatic lrb_setup_t decode_setup(
        input logic [23:0] hdr,
        input logic [7:0]  op,
        input logic [8:0]  depth
    );
        lrb_setup_t s;
        logic [7:0] blen;
        s.ctl_len  = hdr[15:8];
        blen       = hdr[7:0];
        s.is_setup = (hdr[23:16] == op);
        s.sum      = {1'b0, s.ctl_len} + {1'b0, blen};
        s.fits     = (s.ctl_len != 8'd0) && (blen != 8'd0) && (s.sum <= depth);
        return s;
    endfunction

endpackage

// File: rtl/lrb_setup_dec.sv
`timescale 1ns/1ps
module lrb_setup_dec
    import lrb_pkg::*;
#(
    parameter int         DEPTH    = 32,
    parameter logic [7:0] SETUP_OP = 8'hF0
) (
    input  logic [23:0] hdr,
    output lrb_setup_t  info
);
    localparam logic [8:0] DEPTH9 = 9'(DEPTH);

    always_comb info = decode_setup(hdr, SETUP_OP, DEPTH9);
endmodule

// File: rtl/lrb_ring.sv
`timescale 1ns/1ps
module lrb_ring #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lrb_ctrl.sv
`timescale 1ns/1ps
module lrb_ctrl
    import lrb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          f_valid,
    input  logic          d_ready,
    input  logic          exit_valid,
    input  logic          exit_taken,
    input  lrb_setup_t    setup,
    output lrb_state_e    state,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] wr_ptr,
    output logic          wr_en
);
    logic [AW-1:0] ctl_last;
    logic [AW-1:0] tot_last;

    assign wr_en = (state == ST_FILL) && f_valid && d_ready;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state    <= ST_IDLE;
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            ctl_last <= '0;
            tot_last <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (f_valid && setup.is_setup && setup.fits) begin
                        state    <= ST_FILL;
                        wr_ptr   <= '0;
                        ctl_last <= AW'(setup.ctl_len - 8'd1);
                        tot_last <= AW'(setup.sum - 9'd1);
                    end
                end
                ST_FILL: begin
                    if (wr_en) begin
                        wr_ptr <= wr_ptr + AW'(1);
                        if (wr_ptr == tot_last) begin
                            state  <= ST_REPLAY;
                            rd_ptr <= '0;
                        end
                    end
                end
                ST_REPLAY: begin
                    if (d_ready) begin
                        if (rd_ptr == ctl_last) state <= ST_WAIT;
                        if (rd_ptr == tot_last) rd_ptr <= '0;
                        else                    rd_ptr <= rd_ptr + AW'(1);
                    end
                end
                ST_WAIT: begin
                    if (exit_valid) state <= exit_taken ? ST_IDLE : ST_REPLAY;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/loop_replay_buf.sv
`timescale 1ns/1ps
module loop_replay_buf
    import lrb_pkg::*;
#(
    parameter int         WORD_W   = 32,
    parameter int         DEPTH    = 32,
    parameter logic [7:0] SETUP_OP = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              f_valid,
    input  logic [WORD_W-1:0] f_word,
    output logic              f_ready,
    output logic              d_valid,
    output logic [WORD_W-1:0] d_word,
    input  logic              d_ready,
    input  logic              exit_valid,
    input  logic              exit_taken,
    output logic              fetch_hold,
    output logic [1:0]        mode
);
    localparam int AW = $clog2(DEPTH);

    lrb_setup_t        setup;
    lrb_state_e        state;
    logic [AW-1:0]     rd_ptr;
    logic [AW-1:0]     wr_ptr;
    logic              wr_en;
    logic [WORD_W-1:0] ring_word;

    lrb_setup_dec #(.DEPTH(DEPTH), .SETUP_OP(SETUP_OP)) u_dec (
        .hdr  (f_word[WORD_W-1:WORD_W-24]),
        .info (setup)
    );

    lrb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .f_valid    (f_valid),
        .d_ready    (d_ready),
        .exit_valid (exit_valid),
        .exit_taken (exit_taken),
        .setup      (setup),
        .state      (state),
        .rd_ptr     (rd_ptr),
        .wr_ptr     (wr_ptr),
        .wr_en      (wr_en)
    );

    lrb_ring #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (f_word),
        .raddr (rd_ptr),
        .rdata (ring_word)
    );

    always_comb begin
        d_word = f_word;
        case (state)
            ST_IDLE: begin
                d_valid = f_valid && !setup.is_setup;
                f_ready = setup.is_setup ? 1'b1 : d_ready;
            end
            ST_FILL: begin
                d_valid = f_valid;
                f_ready = d_ready;
            end
            ST_REPLAY: begin
                d_valid = 1'b1;
                f_ready = 1'b0;
                d_word  = ring_word;
            end
            default: begin
                d_valid = 1'b0;
                f_ready = 1'b0;
            end
        endcase
    end

    assign fetch_hold = (state == ST_REPLAY) || (state == ST_WAIT);

    always_comb begin
        case (state)
            ST_FILL: mode = MODE_FILL;
            ST_IDLE: mode = MODE_IDLE;
            default: mode = MODE_REPLAY;
        endcase
    end
endmodule

// File: rtl/lrb_checker.sv
`timescale 1ns/1ps
module lrb_checker #(
    parameter int         WORD_W   = 32,
    parameter logic [7:0] SETUP_OP = 8'hF0
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              f_valid,
    input logic [WORD_W-1:0] f_word,
    input logic              f_ready,
    input logic              d_valid,
    input logic [WORD_W-1:0] d_word,
    input logic              d_ready,
    input logic              exit_valid,
    input logic              exit_taken,
    input logic              fetch_hold,
    input logic [1:0]        mode
);
    logic is_op;
    assign is_op = (f_word[WORD_W-1:WORD_W-8] == SETUP_OP);

    a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && !is_op) |-> (d_valid == f_valid && d_word == f_word && f_ready == d_ready));

    a_r3_setup_consumed: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && f_valid && is_op) |-> (f_ready && !d_valid));

    a_r6_hold_blocks_fetch: assert property (@(posedge clk) disable iff (rst)
        fetch_hold |-> (!f_ready && mode == 2'd2));

    a_r7_exit_to_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && !d_valid && exit_valid && exit_taken) |=> (mode == 2'd0));

    a_r8_stall_keeps_word: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && d_valid && !d_ready && !flush) |=> (d_valid && $stable(d_word)));

    a_r9_flush_idle: assert property (@(posedge clk) disable iff (rst)
        flush |=> (mode == 2'd0 && !fetch_hold));

    a_r10_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode != 2'd3);

    a_r11_stray_exit: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && d_valid && exit_valid && !flush) |=> (mode == 2'd2));
endmodule

bind loop_replay_buf lrb_checker #(.WORD_W(WORD_W), .SETUP_OP(SETUP_OP)) u_lrb_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .f_valid    (f_valid),
    .f_word     (f_word),
    .f_ready    (f_ready),
    .d_valid    (d_valid),
    .d_word     (d_word),
    .d_ready    (d_ready),
    .exit_valid (exit_valid),
    .exit_taken (exit_taken),
    .fetch_hold (fetch_hold),
    .mode       (mode)
);

// File: tb/tb_loop_replay_buf.sv
`timescale 1ns/1ps
module tb_loop_replay_buf;
    localparam logic [7:0] OP = 8'hF0;

    logic        clk = 1'b0;
    logic        rst, flush, f_valid, f_ready, d_valid, d_ready;
    logic        exit_valid, exit_taken, fetch_hold;
    logic [31:0] f_word, d_word;
    logic [1:0]  mode;

    int checks = 0;
    int errors = 0;

    logic [31:0] prog  [0:511];
    logic [31:0] exp_w [0:1023];
    string       exp_t [0:1023];
    logic [31:0] loopw [0:63];

    always #2.5 clk = ~clk;

    loop_replay_buf dut (
        .clk(clk), .rst(rst), .flush(flush),
        .f_valid(f_valid), .f_word(f_word), .f_ready(f_ready),
        .d_valid(d_valid), .d_word(d_word), .d_ready(d_ready),
        .exit_valid(exit_valid), .exit_taken(exit_taken),
        .fetch_hold(fetch_hold), .mode(mode)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] rnd_word();
        logic [31:0] w = $urandom;
        if (w[31:24] == OP) w[31:24] = 8'h0F;
        return w;
    endfunction

    function automatic logic [31:0] setup_word(input int c, input int b);
        return {OP, 8'(c), 8'(b), 8'h00};
    endfunction

    task automatic run_episode(input int c, input int b, input int n, input int bad, input int rdy);
        int plen = 0, elen = 0, fidx = 0, eidx = 0, dec = 0, sidx, bidx = -1, guard = 0;
        logic stall = 1'b0;
        logic [31:0] stall_w = '0;
        int pre = $urandom_range(0, 3);
        for (int i = 0; i < pre; i++) begin
            prog[plen] = rnd_word(); exp_w[elen] = prog[plen]; exp_t[elen] = "R2";
            plen++; elen++;
        end
        if (bad != 0) begin
            bidx = plen;
            prog[plen++] = (bad == 1) ? {OP, 8'd0, 8'd3, 8'h00} : {OP, 8'd20, 8'd13, 8'h55};
            prog[plen] = rnd_word(); exp_w[elen] = prog[plen]; exp_t[elen] = "R4";
            plen++; elen++;
        end
        sidx = plen;
        prog[plen++] = setup_word(c, b);
        for (int i = 0; i < c + b; i++) begin
            loopw[i] = rnd_word(); prog[plen++] = loopw[i];
            exp_w[elen] = loopw[i]; exp_t[elen] = "R5"; elen++;
        end
        for (int r = 0; r < n; r++)
            for (int i = 0; i < c + b; i++) begin
                exp_w[elen] = loopw[i]; exp_t[elen] = "R6"; elen++;
            end
        for (int i = 0; i < c; i++) begin
            exp_w[elen] = loopw[i]; exp_t[elen] = "R7"; elen++;
        end
        for (int i = 0; i < 1 + int'($urandom_range(0, 2)); i++) begin
            prog[plen] = rnd_word(); exp_w[elen] = prog[plen]; exp_t[elen] = "R7";
            plen++; elen++;
        end

        while (!(eidx == elen && fidx == plen) && guard < 5000) begin
            @(negedge clk);
            exit_valid = 1'b0; exit_taken = 1'b0;
            if (mode == 2'd2 && !d_valid) begin
                if ($urandom % 2 == 0) begin
                    exit_valid = 1'b1; exit_taken = (dec == n); dec++;
                end
            end else if ($urandom % 6 == 0) begin
                exit_valid = 1'b1; exit_taken = 1'b1;   // stray pulse, R11
            end
            f_valid = (fidx < plen) && ($urandom % 100 < 80);
            f_word  = f_valid ? prog[fidx] : rnd_word();
            d_ready = ($urandom % 100) < rdy;
            #1;
            if (stall) chk(d_valid && d_word == stall_w, "R8", d_word, stall_w);
            if (mode == 2'd2) chk(!f_ready && fetch_hold, "R6", {30'd0, f_ready, fetch_hold}, 32'd1);
            if (f_valid && fidx == sidx) chk(f_ready && !d_valid, "R3", {30'd0, f_ready, d_valid}, 32'd2);
            if (f_valid && fidx == bidx)
                chk(f_ready && !d_valid && mode == 2'd0, "R4", {29'd0, f_ready, d_valid, mode == 2'd0}, 32'd5);
            if (f_valid && fidx > sidx && fidx <= sidx + c + b) chk(mode == 2'd1, "R5", 32'(mode), 32'd1);
            chk(mode != 2'd3, "R10", 32'(mode), 32'd2);
            if (d_valid && d_ready) begin
                if (eidx >= elen) chk(1'b0, "R11", d_word, 32'd0);
                else begin
                    chk(d_word == exp_w[eidx], exp_t[eidx], d_word, exp_w[eidx]);
                    eidx++;
                end
            end
            stall   = (mode == 2'd2) && d_valid && !d_ready;
            stall_w = d_word;
            if (f_valid && f_ready) fidx++;
            guard++;
        end
        if (guard >= 5000) chk(1'b0, "R7", 32'(eidx), 32'(elen));
        @(negedge clk);
        f_valid = 1'b0; exit_valid = 1'b0; exit_taken = 1'b0;
        #1;
        chk(mode == 2'd0 && !fetch_hold, "R7", 32'(mode), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; flush = 1'b0; f_valid = 1'b0; f_word = '0;
        d_ready = 1'b0; exit_valid = 1'b0; exit_taken = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(mode == 2'd0 && !fetch_hold && !d_valid, "R1", {29'd0, mode, fetch_hold}, 32'd0);

        run_episode(1, 1, 0, 0, 100);   // exit on first replay, R7
        run_episode(16, 16, 1, 0, 70);  // fills the store exactly
        run_episode(3, 2, 2, 1, 60);    // zero-length setup ahead, R4
        run_episode(2, 5, 1, 2, 90);    // oversize setup ahead, R4
        run_episode(1, 31, 0, 0, 50);
        for (int k = 0; k < 20; k++)
            run_episode($urandom_range(1, 6), $urandom_range(1, 8), $urandom_range(0, 3),
                        $urandom_range(0, 2), $urandom_range(40, 100));

        // R9: flush in the middle of replay
        @(negedge clk);
        d_ready = 1'b1; f_valid = 1'b1; f_word = setup_word(1, 1);
        @(negedge clk); f_word = 32'h1111_0001;
        @(negedge clk); f_word = 32'h2222_0002;
        @(negedge clk); f_valid = 1'b0; d_ready = 1'b0;
        #1;
        chk(mode == 2'd2 && fetch_hold && d_word == 32'h1111_0001, "R6", d_word, 32'h1111_0001);
        flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        #1;
        chk(mode == 2'd0 && !fetch_hold, "R9", {29'd0, mode, fetch_hold}, 32'd0);
        f_valid = 1'b1; f_word = 32'h3333_0003; d_ready = 1'b1;
        #1;
        chk(d_valid && f_ready && d_word == 32'h3333_0003, "R9", d_word, 32'h3333_0003);
        @(negedge clk); f_valid = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule